// File: doc/BRIEF.md
# Pairwise Transitive Reduction Filter

This block sits beside one core's conflict detector and decides which incoming dependences must be written to the race log. Each event names a remote thread, the timestamp that remote thread had stamped on the conflicting line, the local instruction count, and the dependence kind. The filter keeps one scalar register per remote thread. That register holds the newest source timestamp already logged from that thread. An event whose source timestamp is not newer than this register is already implied by a logged edge, so the filter drops it.

The reduction is pairwise. Each remote thread is tracked on its own, with no vector of timestamps. Under total store order, a write-after-read edge that replay may later remove is always logged. Such an edge never serves to imply later edges. Each logged event leaves the filter one cycle later. It carries a wrapping sequence number, so a consumer can rebuild the order, and the instruction-count difference from the previous logged event, so the log can be compressed.

Top module: `ptr_filter`

## Requirements
- R1: After reset all per-thread registers are zero, the output valid is low, the first logged event carries sequence 0, and its count delta is measured from zero.
- R2: A valid event whose kind is not reserved and whose timestamp is strictly greater than its thread's register is logged. The next cycle, out_valid_o is high and the output carries that event's thread, timestamp, count and kind.
- R3: A valid event whose timestamp is less than or equal to its thread's register is dropped: out_valid_o stays low the next cycle.
- R4: Logging a non-removable event sets that thread's register to the event timestamp. Other threads' registers are unchanged.
- R5: With tso_mode_i high, an event of kind WAR (code 1) with ev_rmv_i high is always logged, with out_rmv_o high. It leaves its thread's register unchanged.
- R6: With tso_mode_i low, ev_rmv_i has no effect. Such a WAR is filtered and updates the register like any other event, and out_rmv_o is low.
- R7: ev_rmv_i has no effect on events of kind RAW (code 0) or WAW (code 2), in either mode.
- R8: An event of the reserved kind code 3 is dropped and updates no register.
- R9: out_seq_o increases by one for each logged event and wraps modulo 2^SEQ_W.
- R10: out_icd_o equals the logged count minus the previously logged count, modulo 2^IC_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tso_mode_i | input | 1 | Total-store-order mode enable |
| ev_valid_i | input | 1 | Incoming dependence event valid |
| ev_tid_i | input | TID_W | Remote thread index |
| ev_ts_i | input | TS_W | Remote source timestamp |
| ev_ic_i | input | IC_W | Local instruction count |
| ev_kind_i | input | 2 | 0 RAW, 1 WAR, 2 WAW, 3 reserved |
| ev_rmv_i | input | 1 | Removable-WAR flag |
| out_valid_o | output | 1 | Logged event valid |
| out_tid_o | output | TID_W | Logged remote thread |
| out_ts_o | output | TS_W | Logged source timestamp |
| out_ic_o | output | IC_W | Logged local count |
| out_kind_o | output | 2 | Logged kind |
| out_rmv_o | output | 1 | Logged edge is a removable WAR |
| out_seq_o | output | SEQ_W | Sequence number of the logged event |
| out_icd_o | output | IC_W | Count delta from the previous logged event |

## Verification
The bench builds the filter with four threads, an 8-bit timestamp and a 4-bit sequence number, and keeps the 64-bit count. The narrow timestamp lets the maximum value 255 be tested directly. The narrow sequence number lets a run of back-to-back logged events wrap it. The full-width count lets a decreasing count exercise the modular delta.

// File: rtl/ptr_pkg.sv
package ptr_pkg;
  typedef enum logic [1:0] {
    DEP_RAW = 2'd0,
    DEP_WAR = 2'd1,
    DEP_WAW = 2'd2,
    DEP_RSV = 2'd3
  } dep_kind_e;
endpackage

// File: rtl/ptr_watermark.sv
module ptr_watermark #(
  parameter int N_THR = 4,
  parameter int TS_W  = 24,
  parameter int TID_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [TID_W-1:0] rd_tid_i,
  input  logic             upd_i,
  input  logic [TID_W-1:0] upd_tid_i,
  input  logic [TS_W-1:0]  upd_ts_i,
  output logic [TS_W-1:0]  rd_ts_o
);
  logic [TS_W-1:0] wm [N_THR];

  for (genvar t = 0; t < N_THR; t++) begin : g_thr
    logic [TS_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= '0;
      else if (upd_i && upd_tid_i == TID_W'(t)) q <= upd_ts_i;
    end
    assign wm[t] = q;
  end

  if (N_THR == 2 ** TID_W) begin : g_full
    assign rd_ts_o = wm[rd_tid_i];
  end else begin : g_part
    assign rd_ts_o = (32'(rd_tid_i) < N_THR) ? wm[rd_tid_i] : '0;
  end
endmodule

// File: rtl/ptr_decide.sv
module ptr_decide
  import ptr_pkg::*;
#(
  parameter int N_THR = 4,
  parameter int TS_W  = 24,
  parameter int TID_W = 2
) (
  input  logic             valid_i,
  input  logic             tso_i,
  input  logic [TID_W-1:0] tid_i,
  input  logic [TS_W-1:0]  ts_i,
  input  logic [1:0]       kind_i,
  input  logic             rmv_i,
  input  logic [TS_W-1:0]  wm_ts_i,
  output logic             fwd_o,
  output logic             upd_o,
  output logic             rmv_eff_o
);
  logic tid_ok, kind_ok, newer;

  if (N_THR == 2 ** TID_W) begin : g_tid_full
    assign tid_ok = 1'b1;
  end else begin : g_tid_chk
    assign tid_ok = 32'(tid_i) < N_THR;
  end

  always_comb begin
    kind_ok   = dep_kind_e'(kind_i) != DEP_RSV;
    // removable WAR only meaningful under TSO
    rmv_eff_o = tso_i && dep_kind_e'(kind_i) == DEP_WAR && rmv_i;
    newer     = ts_i > wm_ts_i;
    fwd_o     = valid_i && kind_ok && tid_ok && (rmv_eff_o || newer);
    upd_o     = fwd_o && !rmv_eff_o;
  end
endmodule

// File: rtl/ptr_emit.sv
module ptr_emit #(
  parameter int TS_W  = 24,
  parameter int TID_W = 2,
  parameter int IC_W  = 64,
  parameter int SEQ_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fwd_i,
  input  logic             rmv_i,
  input  logic [TID_W-1:0] tid_i,
  input  logic [TS_W-1:0]  ts_i,
  input  logic [IC_W-1:0]  ic_i,
  input  logic [1:0]       kind_i,
  output logic             valid_o,
  output logic [TID_W-1:0] tid_o,
  output logic [TS_W-1:0]  ts_o,
  output logic [IC_W-1:0]  ic_o,
  output logic [1:0]       kind_o,
  output logic             rmv_o,
  output logic [SEQ_W-1:0] seq_o,
  output logic [IC_W-1:0]  icd_o
);
  logic [SEQ_W-1:0] seq_q;
  logic [IC_W-1:0]  last_ic_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      tid_o     <= '0;
      ts_o      <= '0;
      ic_o      <= '0;
      kind_o    <= '0;
      rmv_o     <= 1'b0;
      seq_o     <= '0;
      icd_o     <= '0;
      seq_q     <= '0;
      last_ic_q <= '0;
    end else begin
      valid_o <= fwd_i;
      if (fwd_i) begin
        tid_o     <= tid_i;
        ts_o      <= ts_i;
        ic_o      <= ic_i;
        kind_o    <= kind_i;
        rmv_o     <= rmv_i;
        seq_o     <= seq_q;
        icd_o     <= ic_i - last_ic_q;
        seq_q     <= seq_q + 1'b1;
        last_ic_q <= ic_i;
      end
    end
  end
endmodule

// File: rtl/ptr_filter.sv
module ptr_filter #(
  parameter int N_THR = 4,
  parameter int TS_W  = 24,
  parameter int IC_W  = 64,
  parameter int SEQ_W = 8,
  localparam int TID_W = (N_THR > 1) ? $clog2(N_THR) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tso_mode_i,
  input  logic             ev_valid_i,
  input  logic [TID_W-1:0] ev_tid_i,
  input  logic [TS_W-1:0]  ev_ts_i,
  input  logic [IC_W-1:0]  ev_ic_i,
  input  logic [1:0]       ev_kind_i,
  input  logic             ev_rmv_i,
  output logic             out_valid_o,
  output logic [TID_W-1:0] out_tid_o,
  output logic [TS_W-1:0]  out_ts_o,
  output logic [IC_W-1:0]  out_ic_o,
  output logic [1:0]       out_kind_o,
  output logic             out_rmv_o,
  output logic [SEQ_W-1:0] out_seq_o,
  output logic [IC_W-1:0]  out_icd_o
);
  logic [TS_W-1:0] wm_ts;
  logic            fwd, upd, rmv_eff;

  ptr_watermark #(.N_THR(N_THR), .TS_W(TS_W), .TID_W(TID_W)) u_wm (
    .clk_i, .rst_ni,
    .rd_tid_i (ev_tid_i),
    .upd_i    (upd),
    .upd_tid_i(ev_tid_i),
    .upd_ts_i (ev_ts_i),
    .rd_ts_o  (wm_ts)
  );

  ptr_decide #(.N_THR(N_THR), .TS_W(TS_W), .TID_W(TID_W)) u_dec (
    .valid_i  (ev_valid_i),
    .tso_i    (tso_mode_i),
    .tid_i    (ev_tid_i),
    .ts_i     (ev_ts_i),
    .kind_i   (ev_kind_i),
    .rmv_i    (ev_rmv_i),
    .wm_ts_i  (wm_ts),
    .fwd_o    (fwd),
    .upd_o    (upd),
    .rmv_eff_o(rmv_eff)
  );

  ptr_emit #(.TS_W(TS_W), .TID_W(TID_W), .IC_W(IC_W), .SEQ_W(SEQ_W)) u_emit (
    .clk_i, .rst_ni,
    .fwd_i  (fwd),
    .rmv_i  (rmv_eff),
    .tid_i  (ev_tid_i),
    .ts_i   (ev_ts_i),
    .ic_i   (ev_ic_i),
    .kind_i (ev_kind_i),
    .valid_o(out_valid_o),
    .tid_o  (out_tid_o),
    .ts_o   (out_ts_o),
    .ic_o   (out_ic_o),
    .kind_o (out_kind_o),
    .rmv_o  (out_rmv_o),
    .seq_o  (out_seq_o),
    .icd_o  (out_icd_o)
  );
endmodule

// File: rtl/ptr_filter_chk.sv
module ptr_filter_chk #(
  parameter int N_THR = 4,
  parameter int TS_W  = 24,
  parameter int IC_W  = 64,
  parameter int SEQ_W = 8,
  localparam int TID_W = (N_THR > 1) ? $clog2(N_THR) : 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tso_mode_i,
  input logic             ev_valid_i,
  input logic [TID_W-1:0] ev_tid_i,
  input logic [TS_W-1:0]  ev_ts_i,
  input logic [IC_W-1:0]  ev_ic_i,
  input logic [1:0]       ev_kind_i,
  input logic             ev_rmv_i,
  input logic             out_valid_o,
  input logic [TID_W-1:0] out_tid_o,
  input logic [TS_W-1:0]  out_ts_o,
  input logic [IC_W-1:0]  out_ic_o,
  input logic [1:0]       out_kind_o,
  input logic             out_rmv_o,
  input logic [SEQ_W-1:0] out_seq_o,
  input logic [IC_W-1:0]  out_icd_o
);
  logic [SEQ_W-1:0] n_out_q;
  logic [IC_W-1:0]  prev_ic_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      n_out_q   <= '0;
      prev_ic_q <= '0;
    end else if (out_valid_o) begin
      n_out_q   <= n_out_q + 1'b1;
      prev_ic_q <= out_ic_o;
    end
  end

  // R2
  fwd_echo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> $past(ev_valid_i) && out_tid_o == $past(ev_tid_i) &&
      out_ts_o == $past(ev_ts_i) && out_ic_o == $past(ev_ic_i) &&
      out_kind_o == $past(ev_kind_i));

  // R3
  zero_ts_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_valid_i && ev_ts_i == '0 && !(tso_mode_i && ev_kind_i == 2'd1 && ev_rmv_i)
      |=> !out_valid_o);

  // R5
  rmv_war_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_rmv_o && out_valid_o |-> out_kind_o == 2'd1 && $past(tso_mode_i));

  // R8
  rsv_kind_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> out_kind_o != 2'd3);

  // R9
  seq_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> out_seq_o == n_out_q);

  // R10
  icd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> out_icd_o == out_ic_o - prev_ic_q);
endmodule

bind ptr_filter ptr_filter_chk #(
  .N_THR(N_THR), .TS_W(TS_W), .IC_W(IC_W), .SEQ_W(SEQ_W)
) u_chk (.*);

// File: tb/tb_ptr_filter.sv
module tb_ptr_filter;
  localparam int NT = 4, TSW = 8, ICW = 64, SQW = 4, TIDW = 2;

  logic            clk = 1'b0, rst_n = 1'b0, tso = 1'b0;
  logic            ev_valid = 1'b0, ev_rmv = 1'b0;
  logic [TIDW-1:0] ev_tid = '0;
  logic [TSW-1:0]  ev_ts = '0;
  logic [ICW-1:0]  ev_ic = '0;
  logic [1:0]      ev_kind = '0;
  logic            o_valid, o_rmv;
  logic [TIDW-1:0] o_tid;
  logic [TSW-1:0]  o_ts;
  logic [ICW-1:0]  o_ic, o_icd;
  logic [1:0]      o_kind;
  logic [SQW-1:0]  o_seq;

  always #2 clk = ~clk;

  ptr_filter #(.N_THR(NT), .TS_W(TSW), .IC_W(ICW), .SEQ_W(SQW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .tso_mode_i(tso),
    .ev_valid_i(ev_valid), .ev_tid_i(ev_tid), .ev_ts_i(ev_ts), .ev_ic_i(ev_ic),
    .ev_kind_i(ev_kind), .ev_rmv_i(ev_rmv),
    .out_valid_o(o_valid), .out_tid_o(o_tid), .out_ts_o(o_ts), .out_ic_o(o_ic),
    .out_kind_o(o_kind), .out_rmv_o(o_rmv), .out_seq_o(o_seq), .out_icd_o(o_icd)
  );

  typedef struct {
    bit              vld;
    logic [TIDW-1:0] tid;
    logic [TSW-1:0]  ts;
    logic [ICW-1:0]  ic;
    logic [1:0]      kind;
    bit              rmv;
    logic [SQW-1:0]  seq;
    logic [ICW-1:0]  icd;
    int              due;
    string           tag;
  } exp_t;

  exp_t q[$];
  int total = 0, bad = 0, cyc = 0;
  logic [TSW-1:0] m_wm [NT];
  logic [SQW-1:0] m_seq;
  logic [ICW-1:0] m_last;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (q.size() > 0 && q[0].due == cyc) begin
        exp_t e;
        e = q.pop_front();
        chk(o_valid == e.vld, e.tag, "valid", 64'(o_valid), 64'(e.vld));
        if (e.vld && o_valid) begin
          chk(o_tid == e.tid, e.tag, "tid", 64'(o_tid), 64'(e.tid));
          chk(o_ts == e.ts, e.tag, "ts", 64'(o_ts), 64'(e.ts));
          chk(o_ic == e.ic, e.tag, "ic", o_ic, e.ic);
          chk(o_kind == e.kind, e.tag, "kind", 64'(o_kind), 64'(e.kind));
          chk(o_rmv == e.rmv, e.tag, "rmv", 64'(o_rmv), 64'(e.rmv));
          chk(o_seq == e.seq, {e.tag, "/R9"}, "seq", 64'(o_seq), 64'(e.seq));
          chk(o_icd == e.icd, {e.tag, "/R10"}, "icd", o_icd, e.icd);
        end
      end else if (o_valid) begin
        chk(1'b0, "R3", "unexpected valid", 64'(o_valid), 64'd0);
      end
    end
  end

  // driver: one event per call, back to back
  task automatic send(input int tid, input int ts, input logic [63:0] ic,
                      input int kind, input bit rmv, input bit tso_v, input string tag);
    exp_t e;
    bit reff, fwd;
    @(negedge clk);
    tso = tso_v; ev_valid = 1'b1; ev_tid = TIDW'(tid); ev_ts = TSW'(ts);
    ev_ic = ic; ev_kind = 2'(kind); ev_rmv = rmv;
    reff = tso_v && kind == 1 && rmv;
    fwd  = kind != 3 && (reff || TSW'(ts) > m_wm[tid]);
    e.vld = fwd; e.tid = TIDW'(tid); e.ts = TSW'(ts); e.ic = ic; e.kind = 2'(kind);
    e.rmv = reff; e.seq = m_seq; e.icd = ic - m_last; e.due = cyc + 1; e.tag = tag;
    if (fwd) begin
      m_seq = m_seq + 1'b1;
      m_last = ic;
      if (!reff) m_wm[tid] = TSW'(ts);
    end
    q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ev_valid = 1'b0; ev_rmv = 1'b0;
    end
  endtask

  initial begin
    for (int i = 0; i < NT; i++) m_wm[i] = '0;
    m_seq = '0; m_last = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(o_valid == 1'b0, "R1", "valid after reset", 64'(o_valid), 64'd0);
    send(0, 5, 64'd100, 0, 0, 0, "R1/R2");            // first log: seq 0, icd 100
    send(0, 5, 64'd101, 0, 0, 0, "R3");               // equal -> drop
    send(0, 3, 64'd102, 2, 0, 0, "R3");               // older -> drop
    send(0, 0, 64'd103, 0, 0, 0, "R3");               // zero -> drop
    send(1, 3, 64'd104, 2, 0, 0, "R4");               // other thread independent
    send(0, 6, 64'd105, 1, 0, 0, "R2/R4");
    send(1, 3, 64'd106, 0, 0, 0, "R4");               // thread1 now 3 -> drop
    // TSO removable WAR
    send(2, 10, 64'd110, 1, 1, 1, "R5");
    send(2, 4, 64'd111, 0, 0, 1, "R5");               // reg unchanged -> logged
    send(2, 2, 64'd112, 1, 1, 1, "R5");               // always logged
    send(2, 4, 64'd113, 2, 0, 1, "R5");               // reg now 4 -> drop
    // flag ignored outside TSO
    send(3, 9, 64'd120, 1, 1, 0, "R6");
    send(3, 9, 64'd121, 1, 1, 0, "R6");               // filtered -> drop
    // flag ignored on RAW/WAW
    send(3, 20, 64'd130, 0, 1, 1, "R7");
    send(3, 20, 64'd131, 2, 1, 1, "R7");              // drop
    send(3, 15, 64'd132, 0, 1, 1, "R7");              // drop
    // reserved kind
    send(1, 200, 64'd140, 3, 0, 0, "R8");
    send(1, 100, 64'd141, 2, 0, 0, "R8");             // logged: no update by 200
    send(1, 150, 64'd142, 3, 1, 1, "R8");
    // timestamp maximum
    send(0, 255, 64'd150, 0, 0, 0, "R2");
    send(0, 255, 64'd151, 1, 0, 1, "R3");
    idle(2);
    // sequence wrap with back-to-back logging
    for (int i = 0; i < 20; i++) send(1, 101 + i, 64'd200 + 64'(i), 0, 0, 0, "R9");
    // count delta wrap: decreasing count
    send(2, 1, 64'd7, 1, 1, 1, "R10");
    send(2, 1, 64'hFFFF_FFFF_FFFF_FFF0, 1, 1, 1, "R10");
    send(2, 1, 64'd3, 1, 1, 1, "R10");
    idle(4);
    chk(q.size() == 0, "R2", "pending expectations", 64'(q.size()), 64'd0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    done = 1;
    total++; bad++;
    $display("FAIL R1 watchdog actual=%0d expected=%0d", cyc, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule